// File: doc/BRIEF.md
# Clock-Qualified Peripheral Register Interface

This block is the processor-facing register port of a memory-mapped peripheral. A processor reaches it over a 5-bit address, an 8-bit data path, an active-low select and a read/write direction line. A bus phase input gates every transfer: nothing happens unless the select is low and the phase is high. The data path is split into an input byte, an output byte and an output enable, so the surrounding chip can build the shared bidirectional bus. There are 29 byte-wide registers, at addresses 0 to 28. Addresses 29 to 31 exist in the decode but hold no storage.

The whole register file is presented on a flat output vector for the downstream engine. A second, slow reset request input goes through a filter. The filter clears every register only once that input has been seen low for a sustained run of bus clock cycles. Glitches and short dips on that line leave the contents untouched.

Top module: `periph_regif`

## Requirements
- R1: After the asynchronous system reset, every byte of `regs_flat` is zero and `bus_oe` is low.
- R2: `bus_oe` is high only while `sel_n` is low, `phase` is high and `rd_wr_n` is high. For every other combination of these three inputs it is low.
- R3: During a qualified read of address 0 to 28, `bus_dout` shows that register in the same cycle, with no clock edge in the path.
- R4: A qualified write (`sel_n` low, `phase` high, `rd_wr_n` low) captures `addr` and `bus_din` at each clock edge where it holds. The addressed register takes the captured byte at the first clock edge that samples `phase` low afterwards. Register k sits at `regs_flat[8k+7:8k]`.
- R5: A write aimed at address 29, 30 or 31 leaves every register unchanged.
- R6: A qualified read of address 29, 30 or 31 raises `bus_oe` and drives `bus_dout` to 8'h00.
- R7: When `rst_req_n` is sampled low on 10 consecutive clock edges, all registers become zero at the 10th such edge. They stay zero while the input remains low.
- R8: A low run on `rst_req_n` of 9 edges or fewer changes no register. Any high sample restarts the count.
- R9: A phase in which `sel_n` is high, or in which `rd_wr_n` is high, modifies no register.
- R10: While the filtered clear is active, a write strobe is overridden and the register stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous system reset, active low |
| rst_req_n | input | 1 | Reset request line, filtered, active low |
| phase | input | 1 | Bus phase that qualifies transfers when high |
| sel_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Register address |
| bus_din | input | 8 | Write data from processor |
| bus_dout | output | 8 | Read data to processor |
| bus_oe | output | 1 | Enable for the external data drivers |
| regs_flat | output | 232 | All 29 registers, register k at bits 8k+7:8k |

## Verification
Reads are combinational. `bus_oe` and `bus_dout` are therefore checked one time unit after the bench sets up a qualified phase at a falling clock edge, with no edge in between. A write needs two rising edges: one that samples the qualified phase and one that samples the phase low. The bench checks the register contents at the falling edge that follows the second. For the reset filter, the bench counts rising edges that sample the request low. It checks that the registers are intact after the 9th such edge and zero after the 10th.

// File: rtl/periph_regif_pkg.sv
package periph_regif_pkg;
  localparam int ADDR_W         = 5;
  localparam int DATA_W         = 8;
  localparam int NUM_REGS       = 29;
  localparam int RST_LOW_CYCLES = 10;

  typedef enum logic [1:0] {
    XFER_IDLE  = 2'd0,
    XFER_READ  = 2'd1,
    XFER_WRITE = 2'd2
  } xfer_kind_e;
endpackage

// File: rtl/regif_rst_filter.sv
module regif_rst_filter #(
  parameter int LOW_CYCLES = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_req_n,
  output logic clr,
  output logic [$clog2(LOW_CYCLES+1)-1:0] low_cnt
);
  localparam int CNT_W = $clog2(LOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] THR     = CNT_W'(LOW_CYCLES);
  localparam logic [CNT_W-1:0] THR_M1  = CNT_W'(LOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_low;

  assign req_low = ~rst_req_n;

  always_comb begin
    cnt_d = cnt_q;
    if (!req_low) begin
      cnt_d = '0;
    end else if (cnt_q != THR) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign clr     = req_low && (cnt_q >= THR_M1);
  assign low_cnt = cnt_q;
endmodule

// File: rtl/regif_bus_decode.sv
module regif_bus_decode
  import periph_regif_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          phase,
  input  logic          sel_n,
  input  logic          rd_wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_din,
  output logic          rd_en,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  xfer_kind_e      kind;
  logic            pend_q, pend_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [DW-1:0]   data_q, data_d;
  logic            cap_en;

  always_comb begin
    kind = XFER_IDLE;
    if (!sel_n && phase) begin
      kind = rd_wr_n ? XFER_READ : XFER_WRITE;
    end
  end

  assign rd_en  = (kind == XFER_READ);
  assign cap_en = (kind == XFER_WRITE);

  always_comb begin
    pend_d = pend_q;
    addr_d = addr_q;
    data_d = data_q;
    if (cap_en) begin
      pend_d = 1'b1;
      addr_d = addr;
      data_d = bus_din;
    end else if (!phase) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_stb  = pend_q && !phase;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
endmodule

// File: rtl/regif_regfile.sv
module regif_regfile #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int NREGS = 29
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              clr,
  input  logic              wr_stb,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NREGS*DW-1:0] regs_flat
);
  localparam int FLAT_W = NREGS * DW;

  logic [DW-1:0] regs_q [NREGS];

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    logic          hit;
    logic          en;
    logic [DW-1:0] nxt;

    assign hit = wr_stb && (wr_addr == AW'(gi));
    assign en  = clr || hit;
    assign nxt = clr ? '0 : wr_data;

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        regs_q[gi] <= '0;
      end else if (en) begin
        regs_q[gi] <= nxt;
      end
    end

    assign regs_flat[gi*DW +: DW] = regs_q[gi];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREGS; k++) begin
      if (rd_addr == AW'(k)) begin
        rd_data = regs_q[k];
      end
    end
  end

  logic unused_w;
  assign unused_w = ^FLAT_W;
endmodule

// File: rtl/periph_regif.sv
module periph_regif
  import periph_regif_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int DW         = DATA_W,
  parameter int NREGS      = NUM_REGS,
  parameter int LOW_CYCLES = RST_LOW_CYCLES
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                rst_req_n,
  input  logic                phase,
  input  logic                sel_n,
  input  logic                rd_wr_n,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       bus_din,
  output logic [DW-1:0]       bus_dout,
  output logic                bus_oe,
  output logic [NREGS*DW-1:0] regs_flat
);
  localparam int CNT_W = $clog2(LOW_CYCLES + 1);

  logic             clr;
  logic [CNT_W-1:0] low_cnt;
  logic             rd_en;
  logic             wr_stb;
  logic [AW-1:0]    wr_addr;
  logic [DW-1:0]    wr_data;
  logic [DW-1:0]    rd_data;

  regif_rst_filter #(.LOW_CYCLES(LOW_CYCLES)) u_filt (
    .clk       (clk),
    .arst_n    (arst_n),
    .rst_req_n (rst_req_n),
    .clr       (clr),
    .low_cnt   (low_cnt)
  );

  regif_bus_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk     (clk),
    .arst_n  (arst_n),
    .phase   (phase),
    .sel_n   (sel_n),
    .rd_wr_n (rd_wr_n),
    .addr    (addr),
    .bus_din (bus_din),
    .rd_en   (rd_en),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  regif_regfile #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_rf (
    .clk       (clk),
    .arst_n    (arst_n),
    .clr       (clr),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (addr),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );

  assign bus_oe   = rd_en;
  assign bus_dout = rd_en ? rd_data : '0;
endmodule

// File: rtl/periph_regif_chk.sv
module periph_regif_chk #(
  parameter int AW         = 5,
  parameter int DW         = 8,
  parameter int NREGS      = 29,
  parameter int LOW_CYCLES = 10
) (
  input logic                         clk,
  input logic                         arst_n,
  input logic                         rst_req_n,
  input logic                         phase,
  input logic                         sel_n,
  input logic                         rd_wr_n,
  input logic [AW-1:0]                addr,
  input logic                         bus_oe,
  input logic [NREGS*DW-1:0]          regs_flat,
  input logic                         clr,
  input logic                         wr_stb,
  input logic [AW-1:0]                wr_addr,
  input logic [DW-1:0]                wr_data,
  input logic [$clog2(LOW_CYCLES+1)-1:0] low_cnt
);
  localparam logic [AW-1:0] NR_A = AW'(NREGS);

  logic [AW-1:0] seen_addr;
  logic [DW-1:0] seen_data;
  logic          unimpl_wr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      seen_addr   <= '0;
      seen_data   <= '0;
      unimpl_wr_q <= 1'b0;
    end else begin
      seen_addr   <= wr_addr;
      seen_data   <= wr_data;
      unimpl_wr_q <= phase && !sel_n && !rd_wr_n && (addr >= NR_A);
    end
  end

  p_oe_idle_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (sel_n || !phase || !rd_wr_n) |-> !bus_oe);

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_stb && !clr && (wr_addr < NR_A)) |=> (regs_flat[seen_addr*DW +: DW] == seen_data));

  p_unimpl_ignored_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (unimpl_wr_q && !phase && rst_req_n) |=> $stable(regs_flat));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (!arst_n)
    clr |=> (regs_flat == '0));

  p_short_low_r8: assert property (@(posedge clk) disable iff (!arst_n)
    rst_req_n |-> !clr);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!arst_n)
    low_cnt <= ($clog2(LOW_CYCLES+1))'(LOW_CYCLES));
endmodule

bind periph_regif periph_regif_chk #(
  .AW(AW), .DW(DW), .NREGS(NREGS), .LOW_CYCLES(LOW_CYCLES)
) chk_i (
  .clk       (clk),
  .arst_n    (arst_n),
  .rst_req_n (rst_req_n),
  .phase     (phase),
  .sel_n     (sel_n),
  .rd_wr_n   (rd_wr_n),
  .addr      (addr),
  .bus_oe    (bus_oe),
  .regs_flat (regs_flat),
  .clr       (clr),
  .wr_stb    (wr_stb),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .low_cnt   (low_cnt)
);

// File: tb/periph_regif_tb_top.sv
`timescale 1ns/1ps
module periph_regif_tb_top;
  localparam int NR = 29;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          rst_req_n;
  logic          phase;
  logic          sel_n;
  logic          rd_wr_n;
  logic [4:0]    addr;
  logic [7:0]    bus_din;
  logic [7:0]    bus_dout;
  logic          bus_oe;
  logic [NR*8-1:0] regs_flat;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7:0] model [NR];

  always #5 clk = ~clk;

  periph_regif dut_i (
    .clk(clk), .arst_n(arst_n), .rst_req_n(rst_req_n), .phase(phase),
    .sel_n(sel_n), .rd_wr_n(rd_wr_n), .addr(addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .regs_flat(regs_flat)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [NR*8-1:0] e;
    for (int k = 0; k < NR; k++) e[k*8 +: 8] = model[k];
    check(req, 256'(regs_flat), 256'(e));
  endtask

  task automatic idle();
    phase = 1'b0; sel_n = 1'b1; rd_wr_n = 1'b1;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    phase = 1'b1; sel_n = 1'b0; rd_wr_n = 1'b0; addr = a; bus_din = d;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic bus_read(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    phase = 1'b1; sel_n = 1'b0; rd_wr_n = 1'b1; addr = a;
    #1;
    check(req, 256'(bus_oe), 256'(1'b1));
    check(req, 256'(bus_dout), 256'(exp));
    @(negedge clk);
    idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; rst_req_n = 1'b1; idle(); addr = '0; bus_din = '0;
    for (int k = 0; k < NR; k++) model[k] = 8'h00;
    #23 arst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    check("R1", 256'(bus_oe), 256'(1'b0));

    // R2: every select/phase/direction combination
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      sel_n = c[0]; phase = c[1]; rd_wr_n = c[2];
      #1;
      check("R2", 256'(bus_oe), 256'(c == 6));
    end
    @(negedge clk); idle();
    @(negedge clk);
    check_all("R9");

    // R4/R5: two patterns across all 32 addresses
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 32; a++) begin
        logic [7:0] d;
        d = 8'((a * 37 + 5) ^ (p * 8'hA5));
        bus_write(5'(a), d);
        if (a < NR) begin
          model[a] = d;
          check("R4", 256'(regs_flat[a*8 +: 8]), 256'(d));
        end else begin
          check_all("R5");
        end
      end
      check_all("R4");
      for (int a = 0; a < 32; a++) begin
        if (a < NR) bus_read("R3", 5'(a), model[a]);
        else        bus_read("R6", 5'(a), 8'h00);
      end
    end

    // R9: phase with select high, and a read phase, change nothing
    @(negedge clk);
    phase = 1'b1; sel_n = 1'b1; rd_wr_n = 1'b0; addr = 5'd3; bus_din = 8'h11;
    @(negedge clk); idle(); @(negedge clk);
    check_all("R9");
    @(negedge clk);
    phase = 1'b1; sel_n = 1'b0; rd_wr_n = 1'b1; addr = 5'd4; bus_din = 8'h22;
    @(negedge clk); idle(); @(negedge clk);
    check_all("R9");

    // R8: 9-edge dips, separated by one high sample
    @(negedge clk); rst_req_n = 1'b0;
    repeat (9) @(negedge clk);
    rst_req_n = 1'b1;
    @(negedge clk); rst_req_n = 1'b0;
    repeat (9) @(negedge clk);
    check_all("R8");
    rst_req_n = 1'b1;
    @(negedge clk);
    check_all("R8");

    // R7: tenth low edge clears
    rst_req_n = 1'b0;
    repeat (9) @(negedge clk);
    check_all("R7");
    @(negedge clk);
    for (int k = 0; k < NR; k++) model[k] = 8'h00;
    check_all("R7");

    // R10: write while clear held is overridden
    bus_write(5'd7, 8'h5C);
    check("R10", 256'(regs_flat[7*8 +: 8]), 256'(8'h00));
    rst_req_n = 1'b1;
    @(negedge clk);
    bus_write(5'd7, 8'h5C);
    model[7] = 8'h5C;
    check_all("R4");
    bus_read("R3", 5'd7, 8'h5C);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule